// File: doc/BRIEF.md
# Companded PCM Code Format Remapper

This block rewrites 8-bit companded PCM codes between two bit assignments: a sign-magnitude layout that is the same for both companding laws, and the standard G.711 layout for the μ-law or the A-law curve. It does not expand codes to linear PCM and does not compress linear samples. It changes only how the code bits are assigned, so that logic downstream always sees one format.

The caller gives the format of the incoming code and the format it wants out. When the two formats match, the code passes through unchanged. When they differ, the code is XORed with a mask that depends on the law: 0x7F for μ-law and 0x55 for A-law. The mapping is its own inverse, so the same mask serves both directions.

The result is registered. A valid flag moves through the block with the data, and the output code holds its value when no valid input arrives.

Top module: `g711_code_remap`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `outCode` is 8'h00.
- R2: `outValid` is high in the cycle after a rising clock edge at which `inValid` was sampled high, and low in the cycle after an edge at which `inValid` was sampled low.
- R3: When `inFmt` equals `outFmt`, an accepted code appears on `outCode` unchanged one cycle later, for either value of `lawSel`.
- R4: With `lawSel` = 0 (μ-law) and `inFmt` different from `outFmt` (format value 1 = G.711, 0 = sign-magnitude), `outCode` equals the accepted code XOR 8'h7F.
- R5: With `lawSel` = 1 (A-law) and the formats differing, `outCode` equals the accepted code XOR 8'h55.
- R6: While `inValid` is low, `outCode` keeps its last value whatever `inCode`, `lawSel`, `inFmt` and `outFmt` do.
- R7: Converting a code from one format to the other and then back again returns the original code, for both laws.
- R8: The sign-magnitude codes +full scale 8'hFF, +zero 8'h80, -zero 8'h00 and -full scale 8'h7F become 8'h80, 8'hFF, 8'h7F and 8'h00 in μ-law G.711, and 8'hAA, 8'hD5, 8'h55 and 8'h2A in A-law G.711.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A code is presented this cycle |
| inCode | input | 8 | Incoming companded code |
| lawSel | input | 1 | Companding law: 0 = μ-law, 1 = A-law |
| inFmt | input | 1 | Format of `inCode`: 1 = G.711, 0 = sign-magnitude |
| outFmt | input | 1 | Format wanted on `outCode`: 1 = G.711, 0 = sign-magnitude |
| outValid | output | 1 | `outCode` holds a newly converted code |
| outCode | output | 8 | Registered converted code |

## Verification
The assertions assume that `inValid` is low while reset is held and that every control input is stable around the sampling edge. The stimulus meets both conditions: it holds `inValid` at 0 during reset and changes all inputs only on falling edges. Every combination of code value, law and format pair is driven once with `inValid` high. Idle cycles are added in which the code and the control inputs change while `inValid` stays low, to show that the output register ignores them.

// File: rtl/g711r_pkg.sv
package g711r_pkg;

  localparam int unsigned CODE_W = 8;

  // strobes sent from control to the datapath
  typedef struct packed {
    logic load;     // capture a new code this edge
    logic invert;   // formats differ: apply the law mask
    logic useAlaw;  // pick the A-law mask instead of the μ-law mask
  } remapCtl_t;

endpackage

// File: rtl/g711r_ctrl.sv
module g711r_ctrl
  import g711r_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      lawSel,
  input  logic      inFmt,
  input  logic      outFmt,
  output remapCtl_t ctl,
  output logic      outValid
);

  always_comb begin
    ctl.load    = inValid;
    ctl.invert  = inFmt ^ outFmt;
    ctl.useAlaw = lawSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_RISES: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid) |=> outValid);  // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !inValid) |=> !outValid);  // R2

endmodule

// File: rtl/g711r_dpath.sv
module g711r_dpath
  import g711r_pkg::*;
#(
  parameter int unsigned      W       = CODE_W,
  parameter logic [W-1:0]     MU_MASK = 8'h7F,
  parameter logic [W-1:0]     A_MASK  = 8'h55
)(
  input  logic         clk,
  input  logic         rstN,
  input  remapCtl_t    ctl,
  input  logic [W-1:0] inCode,
  output logic [W-1:0] outCode
);

  logic [W-1:0] lawMask;
  logic [W-1:0] flipMask;
  logic [W-1:0] nextCode;

  assign lawMask  = ctl.useAlaw ? A_MASK : MU_MASK;
  assign flipMask = ctl.invert ? lawMask : '0;

  // per-bit conditional inversion
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign nextCode[b] = inCode[b] ^ flipMask[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN)         outCode <= '0;
    else if (ctl.load) outCode <= nextCode;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !ctl.load) |=> $stable(outCode));  // R6
  AST_PASS_SAME_FMT: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && ctl.load && !ctl.invert) |=> (outCode == $past(inCode)));  // R3

endmodule

// File: rtl/g711_code_remap.sv
module g711_code_remap
  import g711r_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CODE_W-1:0] inCode,
  input  logic              lawSel,
  input  logic              inFmt,
  input  logic              outFmt,
  output logic              outValid,
  output logic [CODE_W-1:0] outCode
);

  remapCtl_t ctl;

  g711r_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .lawSel   (lawSel),
    .inFmt    (inFmt),
    .outFmt   (outFmt),
    .ctl      (ctl),
    .outValid (outValid)
  );

  g711r_dpath #(.W(CODE_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inCode  (inCode),
    .outCode (outCode)
  );

  AST_MU_REMAP: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid && !lawSel && (inFmt != outFmt))
      |=> (outCode == ($past(inCode) ^ 8'h7F)));  // R4
  AST_A_REMAP: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid && lawSel && (inFmt != outFmt))
      |=> (outCode == ($past(inCode) ^ 8'h55)));  // R5
  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (!outValid && outCode == 8'h00));  // R1

endmodule

// File: tb/tb_g711_code_remap.sv
module tb_g711_code_remap;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inCode = 8'h00;
  logic       lawSel = 1'b0;
  logic       inFmt = 1'b0;
  logic       outFmt = 1'b0;
  logic       outValid;
  logic [7:0] outCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  g711_code_remap dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCode(inCode),
    .lawSel(lawSel), .inFmt(inFmt), .outFmt(outFmt),
    .outValid(outValid), .outCode(outCode)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expectCode(input logic [7:0] c, input logic law,
                                            input logic fi, input logic fo);
    logic [7:0] m;
    m = law ? 8'h55 : 8'h7F;
    return (fi != fo) ? (c ^ m) : c;
  endfunction

  // drive one valid code, return result one cycle later (sampled at negedge)
  task automatic convert(input logic [7:0] c, input logic law, input logic fi,
                         input logic fo, output logic [7:0] res, output logic vld);
    inCode = c; lawSel = law; inFmt = fi; outFmt = fo; inValid = 1'b1;
    @(negedge clk);
    res = outCode; vld = outValid;
  endtask

  initial begin
    logic [7:0] r, r2;
    logic v;
    @(negedge clk); @(negedge clk);
    check8("R1 outValid", {7'd0, outValid}, 8'h00);
    check8("R1 outCode", outCode, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // exhaustive sweep R3/R4/R5
    for (int law = 0; law < 2; law++)
      for (int fi = 0; fi < 2; fi++)
        for (int fo = 0; fo < 2; fo++)
          for (int c = 0; c < 256; c++) begin
            convert(8'(c), law[0], fi[0], fo[0], r, v);
            if (fi == fo) check8("R3", r, 8'(c));
            else if (law == 0) check8("R4", r, expectCode(8'(c), 1'b0, fi[0], fo[0]));
            else check8("R5", r, expectCode(8'(c), 1'b1, fi[0], fo[0]));
            check8("R2 valid high", {7'd0, v}, 8'h01);
          end

    // R8 anchor codes, sign-magnitude -> G.711
    begin
      logic [7:0] sm [4] = '{8'hFF, 8'h80, 8'h00, 8'h7F};
      logic [7:0] mu [4] = '{8'h80, 8'hFF, 8'h7F, 8'h00};
      logic [7:0] al [4] = '{8'hAA, 8'hD5, 8'h55, 8'h2A};
      for (int i = 0; i < 4; i++) begin
        convert(sm[i], 1'b0, 1'b0, 1'b1, r, v);
        check8("R8 mu", r, mu[i]);
        convert(sm[i], 1'b1, 1'b0, 1'b1, r, v);
        check8("R8 A", r, al[i]);
      end
    end

    // R7 round trip
    for (int law = 0; law < 2; law++)
      for (int c = 0; c < 256; c += 17) begin
        convert(8'(c), law[0], 1'b0, 1'b1, r, v);
        convert(r, law[0], 1'b1, 1'b0, r2, v);
        check8("R7", r2, 8'(c));
      end

    // R2 drop and R6 hold
    convert(8'h3C, 1'b1, 1'b0, 1'b1, r, v);
    inValid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      inCode = 8'(k * 41 + 7); lawSel = k[0]; inFmt = k[1]; outFmt = ~k[0];
      @(negedge clk);
      check8("R2 valid low", {7'd0, outValid}, 8'h00);
      check8("R6 hold", outCode, 8'h3C ^ 8'h55);
    end

    // R1 reset again mid-run
    rstN = 1'b0;
    @(negedge clk);
    check8("R1 re-reset code", outCode, 8'h00);
    check8("R1 re-reset valid", {7'd0, outValid}, 8'h00);
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 20000 && !done; n++) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule